// File: doc/BRIEF.md
# Two-Band Polyphase Sub-Band Analysis Filter

This block takes a stream of signed linear PCM samples and produces two half-rate signals: a low band and a high band. The two bands split the spectrum at a quarter of the input rate. Both bands come from one symmetric low-pass prototype of NTAPS coefficients, where NTAPS is even. The prototype is split into its even-indexed and odd-indexed halves. Each half runs as an NTAPS/2-tap filter at half the input rate. A sum/difference stage then yields the two bands, so the block has no separate high-pass filter.

A small two-state commutator steers samples. State `PH_ODD` waits for the first sample of a pair; that sample enters the odd-coefficient branch. State `PH_EVEN` waits for the second sample of the pair; that sample enters the even-coefficient branch. Each accepted sample moves the commutator to the other state: `PH_ODD` to `PH_EVEN` and `PH_EVEN` to `PH_ODD`. An idle cycle keeps the current state.

Each branch keeps its latest result in a working register. When a pair starts, the working registers are copied into a holding pair. The low band is formed from these values during the first half of the pair, and the high band from the holding pair during the second half. Both results are then presented together with a one-cycle strobe. The prototype coefficients come in through a packed parameter, in signed fixed point with FRAC fractional bits.

Top module: `qmf2_analysis`

## Requirements
- R1: While the synchronous reset is high, and on the first cycle after it falls, `out_valid_o` is 0, `low_o` and `high_o` are 0, and the commutator is in `PH_ODD`.
- R2: `out_valid_o` is high for exactly one cycle: the cycle after the clock edge that accepts the second sample of a pair. The second sample is every accepted sample with an odd index, counting from 0 since reset. `out_valid_o` is low in every other cycle.
- R3: Call the accepted samples x(k), with x(k)=0 for k<0, and call the prototype coefficients h(n). The coefficients are signed CW-bit values; h(n) sits at bits [n*CW +: CW] of `COEFS`. The low band of pair m is sum over n of h(n)·x(2m+1−n), rounded and saturated as in R6 and R7.
- R4: The high band of pair m is sum over n of (−1)^n·h(n)·x(2m+1−n), rounded and saturated as in R6 and R7.
- R5: The strobe raised at pair p carries the results of pair p−1. The first strobe after reset therefore carries 0 on both bands. Between strobes, `low_o` and `high_o` hold their values.
- R6: Rounding adds 2^(FRAC−1) to the full-precision sum and then shifts right arithmetically by FRAC bits. An exact half therefore rounds toward +∞.
- R7: A rounded result above 2^(DW−1)−1 is output as 2^(DW−1)−1. A rounded result below −2^(DW−1) is output as −2^(DW−1).
- R8: A cycle with `in_valid_i` low is ignored, whatever `in_sample_i` holds. It does not advance the commutator, does not enter the delay lines, and does not change the outputs.
- R9: A reset asserted in the middle of a stream, including in the middle of a pair, clears all history. Output afterwards equals that of a fresh start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| in_valid_i | input | 1 | Qualifies `in_sample_i` |
| in_sample_i | input | DW | Signed input sample |
| low_o | output | DW | Signed low-band sample |
| high_o | output | DW | Signed high-band sample |
| out_valid_o | output | 1 | One-cycle strobe marking a new band pair |

## Verification
The bench compares every strobe against a direct-form reference. The reference filters the input directly and then decimates. A design that swapped the branch assignment, or that started the commutator in the wrong state, would disagree with it on the quarter-rate tone and on the pseudo-random stream. Full-scale DC of both signs drives the low band into saturation. An unclamped design would wrap to the opposite sign, and the DC high band, which should be exactly zero, would expose a sign error in the difference stage. An impulse of half full-scale against odd coefficients lands every product on an exact half, which separates round-half-up from truncation or round-to-even. Idle cycles carrying garbage data, and a reset inserted between the two samples of a pair, catch a commutator that moves on an invalid cycle or that keeps stale holding values.

// File: rtl/qmf2_pkg.sv
package qmf2_pkg;

    // Commutator position: which polyphase branch takes the next accepted sample.
    typedef enum logic {
        PH_ODD  = 1'b0,   // first sample of a pair, odd-coefficient branch
        PH_EVEN = 1'b1    // second sample of a pair, even-coefficient branch
    } phase_e;

endpackage

// File: rtl/qmf2_commutator.sv
module qmf2_commutator
    import qmf2_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_i,
    input  logic   in_valid_i,
    output logic   load_odd_o,
    output logic   load_even_o,
    output phase_e phase_o
);

    phase_e state_q, state_d;

    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= PH_ODD;
        else       state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_ODD:  if (in_valid_i) state_d = PH_EVEN;
            PH_EVEN: if (in_valid_i) state_d = PH_ODD;
            default: state_d = PH_ODD;
        endcase
    end

    always_comb begin
        load_odd_o  = 1'b0;
        load_even_o = 1'b0;
        unique case (state_q)
            PH_ODD:  load_odd_o  = in_valid_i;
            PH_EVEN: load_even_o = in_valid_i;
            default: ;
        endcase
    end

    assign phase_o = state_q;

    // R8: an accepted sample always flips the commutator
    p_flip_on_valid_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        in_valid_i |=> (state_q != $past(state_q)));

    // R8: an idle cycle leaves the commutator where it was
    p_hold_when_idle_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        !in_valid_i |=> $stable(state_q));

endmodule

// File: rtl/qmf2_branch.sv
module qmf2_branch #(
    parameter int DW     = 16,
    parameter int CW     = 16,
    parameter int NTAPS  = 16,
    parameter int ACCW   = 36,
    parameter int PARITY = 0,
    parameter logic [NTAPS*CW-1:0] COEFS = '0
) (
    input  logic                   clk_i,
    input  logic                   rst_i,
    input  logic                   load_i,
    input  logic signed [DW-1:0]   sample_i,
    output logic signed [ACCW-1:0] work_o
);

    localparam int K  = NTAPS / 2;
    localparam int PW = DW + CW;

    logic signed [DW-1:0]   dl_q [K-1];
    logic signed [DW-1:0]   tap  [K];
    logic signed [PW-1:0]   prod [K];
    logic signed [ACCW-1:0] acc;

    assign tap[0] = sample_i;

    for (genvar j = 1; j < K; j++) begin : g_tap
        assign tap[j] = dl_q[j-1];
    end

    for (genvar j = 0; j < K; j++) begin : g_mul
        localparam int IDX = 2 * j + PARITY;
        logic signed [CW-1:0] coef;
        assign coef    = $signed(COEFS[IDX*CW +: CW]);
        assign prod[j] = PW'(tap[j]) * PW'(coef);
    end

    always_comb begin
        acc = '0;
        for (int j = 0; j < K; j++) begin
            acc = acc + ACCW'(prod[j]);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            for (int j = 0; j < K - 1; j++) dl_q[j] <= '0;
            work_o <= '0;
        end else if (load_i) begin
            dl_q[0] <= sample_i;
            for (int j = 1; j < K - 1; j++) dl_q[j] <= dl_q[j-1];
            work_o <= acc;
        end
    end

    // R8: the working result moves only when this branch takes a sample
    p_work_only_on_load_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        !load_i |=> $stable(work_o));

endmodule

// File: rtl/qmf2_butterfly.sv
module qmf2_butterfly #(
    parameter int DW   = 16,
    parameter int ACCW = 36,
    parameter int FRAC = 15
) (
    input  logic                   clk_i,
    input  logic                   rst_i,
    input  logic                   copy_i,
    input  logic                   emit_i,
    input  logic signed [ACCW-1:0] work_odd_i,
    input  logic signed [ACCW-1:0] work_even_i,
    output logic signed [DW-1:0]   low_o,
    output logic signed [DW-1:0]   high_o,
    output logic                   strobe_o
);

    localparam int SW = ACCW + 1;
    localparam int RW = ACCW + 3;
    localparam logic signed [RW-1:0] OMAX = (RW'(1) <<< (DW - 1)) - RW'(1);
    localparam logic signed [RW-1:0] OMIN = -OMAX - RW'(1);

    logic signed [ACCW-1:0] hold_odd_q, hold_even_q;
    logic signed [DW-1:0]   low_pend_q;
    logic signed [SW-1:0]   sum_w, diff_w;

    function automatic logic signed [DW-1:0] rndsat(input logic signed [SW-1:0] v);
        logic signed [RW-1:0] t;
        t = (RW'(v) + (RW'(1) <<< (FRAC - 1))) >>> FRAC;
        if (t > OMAX)      t = OMAX;
        else if (t < OMIN) t = OMIN;
        return t[DW-1:0];
    endfunction

    // sum taken from the working pair as it is copied; difference from the holding pair
    assign sum_w  = SW'(work_even_i) + SW'(work_odd_i);
    assign diff_w = SW'(hold_even_q) - SW'(hold_odd_q);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            hold_odd_q  <= '0;
            hold_even_q <= '0;
            low_pend_q  <= '0;
            low_o       <= '0;
            high_o      <= '0;
            strobe_o    <= 1'b0;
        end else begin
            strobe_o <= emit_i;
            if (copy_i) begin
                hold_odd_q  <= work_odd_i;
                hold_even_q <= work_even_i;
                low_pend_q  <= rndsat(sum_w);
            end
            if (emit_i) begin
                low_o  <= low_pend_q;
                high_o <= rndsat(diff_w);
            end
        end
    end

    // R2: no two strobes back to back
    p_single_strobe_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        strobe_o |=> !strobe_o);

    // R5: band outputs change only together with the strobe
    p_low_hold_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(low_o) |-> strobe_o);
    p_high_hold_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(high_o) |-> strobe_o);

    // R2: copy and emit never coincide
    p_copy_emit_excl_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        !(copy_i && emit_i));

endmodule

// File: rtl/qmf2_analysis.sv
module qmf2_analysis
    import qmf2_pkg::*;
#(
    parameter int DW    = 16,
    parameter int CW    = 16,
    parameter int NTAPS = 16,
    parameter int FRAC  = 15,
    parameter logic [NTAPS*CW-1:0] COEFS = {
        -16'sd301, 16'sd901, -16'sd1801, 16'sd3001,
        -16'sd4501, 16'sd6501, 16'sd9001, 16'sd12001,
        16'sd12001, 16'sd9001, 16'sd6501, -16'sd4501,
        16'sd3001, -16'sd1801, 16'sd901, -16'sd301}
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 in_valid_i,
    input  logic signed [DW-1:0] in_sample_i,
    output logic signed [DW-1:0] low_o,
    output logic signed [DW-1:0] high_o,
    output logic                 out_valid_o
);

    localparam int HALF = NTAPS / 2;
    localparam int ACCW = DW + CW + $clog2(HALF) + 1;

    logic                   load_odd, load_even;
    phase_e                 phase;
    logic signed [ACCW-1:0] work_odd, work_even;

    qmf2_commutator u_comm (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .in_valid_i  (in_valid_i),
        .load_odd_o  (load_odd),
        .load_even_o (load_even),
        .phase_o     (phase)
    );

    // branch 1 holds the odd-indexed coefficients, branch 0 the even-indexed ones
    for (genvar b = 0; b < 2; b++) begin : g_branch
        logic                   ld;
        logic signed [ACCW-1:0] wk;
        assign ld = (b == 1) ? load_odd : load_even;
        qmf2_branch #(
            .DW(DW), .CW(CW), .NTAPS(NTAPS), .ACCW(ACCW), .PARITY(b), .COEFS(COEFS)
        ) u_fir (
            .clk_i    (clk_i),
            .rst_i    (rst_i),
            .load_i   (ld),
            .sample_i (in_sample_i),
            .work_o   (wk)
        );
    end

    assign work_odd  = g_branch[1].wk;
    assign work_even = g_branch[0].wk;

    qmf2_butterfly #(.DW(DW), .ACCW(ACCW), .FRAC(FRAC)) u_bfly (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .copy_i      (load_odd),
        .emit_i      (load_even),
        .work_odd_i  (work_odd),
        .work_even_i (work_even),
        .low_o       (low_o),
        .high_o      (high_o),
        .strobe_o    (out_valid_o)
    );

    // R1: the first cycle out of reset shows a cleared block
    p_reset_clears_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (!out_valid_o && low_o == '0 && high_o == '0 && phase == PH_ODD));

    // R2: a strobe follows an accepted second-of-pair sample
    p_strobe_source_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        out_valid_o |-> $past(in_valid_i && phase == PH_EVEN));

    // R2: an accepted second-of-pair sample is always followed by a strobe
    p_strobe_follows_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (in_valid_i && phase == PH_EVEN) |=> out_valid_o);

endmodule

// File: tb/qmf2_analysis_bench.sv
module qmf2_analysis_bench;

    localparam int DW = 16;
    localparam int CW = 16;
    localparam int NT = 16;
    localparam int FR = 15;
    localparam int HB [NT] = '{-301, 901, -1801, 3001, -4501, 6501, 9001, 12001,
                               12001, 9001, 6501, -4501, 3001, -1801, 901, -301};

    // stimulus table: kind (0 DC, 1 quarter-rate tone, 2 alternating, 3 pseudo-random,
    // 4 impulse), amplitude, accepted samples, idle cycles after each sample
    localparam int NSEG = 7;
    localparam int SEG_KIND [NSEG] = '{0, 1, 2, 3, 4, 0, 0};
    localparam int SEG_AMP  [NSEG] = '{4000, 10000, 8000, 0, 16384, 32767, -32768};
    localparam int SEG_LEN  [NSEG] = '{40, 48, 32, 64, 32, 32, 32};
    localparam int SEG_GAP  [NSEG] = '{0, 0, 1, 2, 0, 0, 3};

    function automatic logic [NT*CW-1:0] pack_h();
        logic [NT*CW-1:0] r;
        for (int n = 0; n < NT; n++) r[n*CW +: CW] = CW'(HB[n]);
        return r;
    endfunction

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 in_valid = 1'b0;
    logic signed [DW-1:0] in_sample = '0;
    logic signed [DW-1:0] low, high;
    logic                 out_valid;

    int  xh [4096];
    int  nx = 0;
    int  checks = 0;
    int  errors = 0;
    int  prev_low = 0;
    int  prev_high = 0;
    int  cyc = 0;
    bit  after_mid = 1'b0;
    logic [31:0] lcg = 32'h1234_5678;

    always #4 clk = ~clk;

    qmf2_analysis #(.DW(DW), .CW(CW), .NTAPS(NT), .FRAC(FR), .COEFS(pack_h())) u_qmf2_analysis (
        .clk_i       (clk),
        .rst_i       (rst),
        .in_valid_i  (in_valid),
        .in_sample_i (in_sample),
        .low_o       (low),
        .high_o      (high),
        .out_valid_o (out_valid)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            errors = errors + 1;
            $display("FAIL R2 watchdog expired actual %0d expected %0d", cyc, 100000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // direct-form reference: filter at full rate, keep the odd-indexed outputs
    function automatic longint ref_acc(input int m, input bit hi);
        longint a = 0;
        for (int n = 0; n < NT; n++) begin
            int k = 2 * m + 1 - n;
            longint c = (hi && (n % 2 == 1)) ? -longint'(HB[n]) : longint'(HB[n]);
            if (k >= 0) a = a + c * longint'(xh[k]);
        end
        return a;
    endfunction

    function automatic longint rnd(input longint a);
        return (a + (64'sd1 <<< (FR - 1))) >>> FR;
    endfunction

    function automatic longint sat(input longint r);
        if (r > 32767) return 32767;
        if (r < -32768) return -32768;
        return r;
    endfunction

    function automatic string band_tag(input longint a, input bit hi, input bit first);
        string t;
        longint r = rnd(a);
        if (first)                               t = "R5";
        else if (r != sat(r))                    t = "R7";
        else if ((a & ((64'sd1 <<< FR) - 1)) == (64'sd1 <<< (FR - 1))) t = "R6";
        else                                     t = hi ? "R4" : "R3";
        if (after_mid) t = {"R9 ", t};
        return t;
    endfunction

    task automatic send(input bit v, input int d);
        @(negedge clk);
        in_valid  = v;
        in_sample = d[DW-1:0];
        @(posedge clk);
        #1;
        if (v) begin
            xh[nx] = d;
            nx = nx + 1;
        end
        if (v && (nx % 2 == 0)) begin
            int m = nx / 2 - 2;
            longint al = (m < 0) ? 0 : ref_acc(m, 1'b0);
            longint ah = (m < 0) ? 0 : ref_acc(m, 1'b1);
            check(out_valid === 1'b1, "R2 strobe after second sample", longint'(out_valid), 1);
            check(longint'(low) == sat(rnd(al)), $sformatf("%s low band pair %0d", band_tag(al, 1'b0, m < 0), m),
                  longint'(low), sat(rnd(al)));
            check(longint'(high) == sat(rnd(ah)), $sformatf("%s high band pair %0d", band_tag(ah, 1'b1, m < 0), m),
                  longint'(high), sat(rnd(ah)));
        end else begin
            check(out_valid === 1'b0, v ? "R2 no strobe on first sample" : "R8 no strobe on idle cycle",
                  longint'(out_valid), 0);
            check(int'(low) == prev_low && int'(high) == prev_high, "R8 R5 outputs hold without strobe",
                  longint'(low), longint'(prev_low));
        end
        prev_low  = int'(low);
        prev_high = int'(high);
        in_valid  = 1'b0;
        in_sample = 16'h5A5A;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst      = 1'b1;
        in_valid = 1'b0;
        @(posedge clk);
        @(posedge clk);
        #1;
        check(out_valid === 1'b0 && low == 0 && high == 0, "R1 cleared during reset",
              longint'(low), 0);
        @(negedge clk);
        rst = 1'b0;
        nx  = 0;
        @(posedge clk);
        #1;
        check(out_valid === 1'b0, "R1 no strobe after reset release", longint'(out_valid), 0);
        check(low == 0 && high == 0, "R1 outputs zero after reset release", longint'(high), 0);
        prev_low  = 0;
        prev_high = 0;
    endtask

    function automatic int next_lcg();
        lcg = lcg * 32'd1103515245 + 32'd12345;
        return int'($signed(lcg[30:15]));
    endfunction

    initial begin
        do_reset();
        for (int s = 0; s < NSEG; s++) begin
            for (int i = 0; i < SEG_LEN[s]; i++) begin
                int v;
                case (SEG_KIND[s])
                    0: v = SEG_AMP[s];
                    1: v = (i % 4 == 1) ? SEG_AMP[s] : ((i % 4 == 3) ? -SEG_AMP[s] : 0);
                    2: v = (i % 2 == 1) ? -SEG_AMP[s] : SEG_AMP[s];
                    3: v = next_lcg();
                    default: v = (i == 0) ? SEG_AMP[s] : 0;
                endcase
                send(1'b1, v);
                for (int g = 0; g < SEG_GAP[s]; g++) send(1'b0, 32'h7FFF - g);
            end
        end
        // R9: reset between the two samples of a pair, then restart
        for (int i = 0; i < 3; i++) send(1'b1, next_lcg());
        do_reset();
        after_mid = 1'b1;
        for (int i = 0; i < 24; i++) begin
            send(1'b1, (i % 4 == 1) ? 12000 : ((i % 4 == 3) ? -12000 : 0));
        end
        for (int i = 0; i < 16; i++) send(1'b1, next_lcg());
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule